// File: doc/BRIEF.md
# Bidirectional Port Controller with Change Interrupt

This block controls an eight-bit general purpose port. Each bit keeps a data latch and a direction latch, both loaded from a register bus by their own write strobes. A direction bit of 1 makes the pin an input, and 0 makes it an output. Some bits can give their driver to a peripheral. On those bits a per-bit select swaps the driven value and the output enable over to the peripheral.

The pins are sampled on every clock edge, and the port read returns that sample. The upper four bits also feed change detection. A port read stores the sampled levels as a reference. A later compare between the sampled levels and that reference sets a shared flag, and the flag holds until software clears it.

A global active-low pull-up enable turns on weak pull-ups for input bits only. When low-voltage programming is enabled, bit 4 becomes the programming input: its driver is released, its pull-up is disabled and it is removed from change detection.

Top module: `bidir_port_ctl`

## Requirements
- R1: While reset is active and after it is released, the direction readback is 8'hFF, the data latch is 0, every output enable is 0 and the change flag is 0.
- R2: A data write strobe loads `wr_bus` into the data latch at the next clock edge. A bit that is not handed to a peripheral then drives that latch bit on `pin_out`.
- R3: A direction write strobe loads `wr_bus` into the direction latch. `rd_dir` returns the latch contents whatever the pin levels are. A bit with direction 0 has its output enabled.
- R4: On the peripheral-capable bits (mask 8'h0E, bits 3..1) with the select at 1, `pin_out` follows `periph_out` and `pin_oe` follows `periph_oe`. The select and the peripheral inputs have no effect on any other bit.
- R5: `rd_data` shows the level `pin_in` had at the most recent clock edge.
- R6: When a sampled bit among 7..4 differs from its reference bit, `chg_flag` goes to 1 one edge after the sample. Differences on bits 3..0 never set it.
- R7: A port read strobe copies the current `rd_data` into the reference at the clock edge. Afterwards, unchanged pins raise no new flag.
- R8: `chg_flag` stays at 1 until `chg_clr` is applied. A clear in a cycle that still has a mismatch leaves the flag at 1.
- R9: While `lvp_en` is 1, bit 4 is excluded from change detection, has no pull-up and no output enable, and `prog_in` shows the sampled bit 4. While `lvp_en` is 0, `prog_in` is 0.
- R10: `pullup_en` bit i is 1 only when `pullup_n` is 0 and direction bit i is 1. R9 adds a further exception for bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_bus | input | 8 | Register write data |
| wr_data_en | input | 1 | Data latch write strobe |
| wr_dir_en | input | 1 | Direction latch write strobe |
| rd_port_en | input | 1 | Port read strobe; stores the change reference |
| rd_data | output | 8 | Sampled pin levels |
| rd_dir | output | 8 | Direction latch contents |
| periph_sel | input | 8 | Per-bit peripheral select |
| periph_out | input | 8 | Peripheral output values |
| periph_oe | input | 8 | Peripheral output enables |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| pullup_n | input | 1 | Global active-low pull-up enable |
| pullup_en | output | 8 | Per-bit weak pull-up enables |
| lvp_en | input | 1 | Low-voltage programming enable |
| prog_in | output | 1 | Programming input taken from bit 4 |
| chg_clr | input | 1 | Clears the change flag |
| chg_flag | output | 1 | Change interrupt flag |

## Verification
Two functions can fall in the same cycle. The first is a flag clear together with a compare that still mismatches. The bench applies `chg_clr` while the changed pin is still held and the reference is stale, and expects the flag to stay at 1. The second is a port read strobe in the same cycle as a new pin change. The bench expects the reference to take the sampled value from before that edge, so the flag still rises one edge later. Pull-up and driver results on bit 4 are checked with `lvp_en` on and off while the bit toggles.

// File: rtl/bport_pkg.sv
package bport_pkg;
  typedef struct packed {
    logic out;
    logic oe;
    logic pu;
  } pad_drv_t;

  function automatic logic [7:0] upper_mask(input int width, input int lo);
    logic [7:0] m;
    m = '0;
    for (int i = 0; i < 8; i++) begin
      if (i >= lo && i < width) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/bport_latches.sv
module bport_latches #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] wr_bus,
  input  logic             wr_data_en,
  input  logic             wr_dir_en,
  output logic [WIDTH-1:0] data_q,
  output logic [WIDTH-1:0] dir_q
);
  logic [WIDTH-1:0] data_d, dir_d;

  always_comb begin
    data_d = data_q;
    dir_d  = dir_q;
    if (wr_data_en) data_d = wr_bus;
    if (wr_dir_en)  dir_d  = wr_bus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '1;
    end else begin
      data_q <= data_d;
      dir_q  <= dir_d;
    end
  end
endmodule

// File: rtl/bport_pad_drv.sv
module bport_pad_drv
  import bport_pkg::*;
#(
  parameter bit CAPABLE = 1'b0,
  parameter bit IS_LVP  = 1'b0
) (
  input  logic     data_bit,
  input  logic     dir_bit,
  input  logic     sel,
  input  logic     p_out,
  input  logic     p_oe,
  input  logic     pullup_n,
  input  logic     lvp_en,
  output pad_drv_t drv
);
  logic take_p;
  logic lvp_hold;

  assign take_p   = CAPABLE & sel;
  assign lvp_hold = IS_LVP & lvp_en;

  always_comb begin
    drv.out = take_p ? p_out : data_bit;
    drv.oe  = take_p ? p_oe  : ~dir_bit;
    if (lvp_hold) drv.oe = 1'b0;
    drv.pu  = ~pullup_n & dir_bit & ~lvp_hold;
  end
endmodule

// File: rtl/bport_chg_det.sv
module bport_chg_det #(
  parameter int         WIDTH    = 8,
  parameter logic [7:0] CHG_MASK = 8'hF0,
  parameter int         LVP_BIT  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_in,
  input  logic             rd_port_en,
  input  logic             chg_clr,
  input  logic             lvp_en,
  output logic [WIDTH-1:0] pin_q,
  output logic             flag_q
);
  logic [WIDTH-1:0] ref_q, ref_d;
  logic [WIDTH-1:0] watch;
  logic [WIDTH-1:0] diff;
  logic             flag_d;

  always_comb begin
    watch = CHG_MASK[WIDTH-1:0];
    if (lvp_en) watch[LVP_BIT] = 1'b0;
    diff   = (pin_q ^ ref_q) & watch;
    ref_d  = rd_port_en ? pin_q : ref_q;
    flag_d = (|diff) | (flag_q & ~chg_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= '0;
      ref_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      pin_q  <= pin_in;
      ref_q  <= ref_d;
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/bidir_port_ctl.sv
module bidir_port_ctl
  import bport_pkg::*;
#(
  parameter int         WIDTH       = 8,
  parameter int         CHG_LO      = 4,
  parameter int         LVP_BIT     = 4,
  parameter logic [7:0] PERIPH_MASK = 8'h0E
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] wr_bus,
  input  logic             wr_data_en,
  input  logic             wr_dir_en,
  input  logic             rd_port_en,
  output logic [WIDTH-1:0] rd_data,
  output logic [WIDTH-1:0] rd_dir,
  input  logic [WIDTH-1:0] periph_sel,
  input  logic [WIDTH-1:0] periph_out,
  input  logic [WIDTH-1:0] periph_oe,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  input  logic             pullup_n,
  output logic [WIDTH-1:0] pullup_en,
  input  logic             lvp_en,
  output logic             prog_in,
  input  logic             chg_clr,
  output logic             chg_flag
);
  localparam logic [7:0] CHG_MASK = upper_mask(WIDTH, CHG_LO);

  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic [WIDTH-1:0] data_q, dir_q, pin_q;
  pad_drv_t         drv [WIDTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  bport_latches #(.WIDTH(WIDTH)) u_latch (
    .clk(clk), .rst_n(rst_int_n), .wr_bus(wr_bus),
    .wr_data_en(wr_data_en), .wr_dir_en(wr_dir_en),
    .data_q(data_q), .dir_q(dir_q)
  );

  bport_chg_det #(.WIDTH(WIDTH), .CHG_MASK(CHG_MASK), .LVP_BIT(LVP_BIT)) u_chg (
    .clk(clk), .rst_n(rst_int_n), .pin_in(pin_in), .rd_port_en(rd_port_en),
    .chg_clr(chg_clr), .lvp_en(lvp_en), .pin_q(pin_q), .flag_q(chg_flag)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    bport_pad_drv #(.CAPABLE(PERIPH_MASK[i]), .IS_LVP(i == LVP_BIT)) u_pad (
      .data_bit(data_q[i]), .dir_bit(dir_q[i]), .sel(periph_sel[i]),
      .p_out(periph_out[i]), .p_oe(periph_oe[i]), .pullup_n(pullup_n),
      .lvp_en(lvp_en), .drv(drv[i])
    );
    assign pin_out[i]   = drv[i].out;
    assign pin_oe[i]    = drv[i].oe;
    assign pullup_en[i] = drv[i].pu;
  end

  assign rd_data = pin_q;
  assign rd_dir  = dir_q;
  assign prog_in = lvp_en & pin_q[LVP_BIT];
endmodule

// File: rtl/bport_chk.sv
module bport_chk #(
  parameter int WIDTH   = 8,
  parameter int LVP_BIT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] wr_bus,
  input logic             wr_data_en,
  input logic [WIDTH-1:0] rd_data,
  input logic [WIDTH-1:0] rd_dir,
  input logic [WIDTH-1:0] pin_in,
  input logic [WIDTH-1:0] pin_out,
  input logic [WIDTH-1:0] pin_oe,
  input logic [WIDTH-1:0] pullup_en,
  input logic             lvp_en,
  input logic             chg_clr,
  input logic             chg_flag
);
  logic [1:0] live_cnt;
  logic       live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_cnt <= 2'd0;
    else if (live_cnt != 2'd3) live_cnt <= live_cnt + 2'd1;
  end
  assign live = (live_cnt == 2'd3);

  p_data_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (live && wr_data_en) |=> (pin_out[0] == $past(wr_bus[0])));

  p_oe_from_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe[0] == ~rd_dir[0]);

  p_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
    live |=> (rd_data == $past(pin_in)));

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_flag && !chg_clr) |=> chg_flag);

  p_lvp_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lvp_en |-> (!pullup_en[LVP_BIT] && !pin_oe[LVP_BIT]));

  p_pullup_inputs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pullup_en & ~rd_dir) == '0);
endmodule

bind bidir_port_ctl bport_chk #(.WIDTH(WIDTH), .LVP_BIT(LVP_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_bus(wr_bus), .wr_data_en(wr_data_en),
  .rd_data(rd_data), .rd_dir(rd_dir), .pin_in(pin_in), .pin_out(pin_out),
  .pin_oe(pin_oe), .pullup_en(pullup_en), .lvp_en(lvp_en),
  .chg_clr(chg_clr), .chg_flag(chg_flag)
);

// File: tb/tb_bidir_port_ctl.sv
`timescale 1ns/100ps
module tb_bidir_port_ctl;
  localparam int S_DIR = 0, S_RD = 1, S_OUT = 2, S_OE = 3, S_PU = 4, S_FLAG = 5, S_PROG = 6;

  typedef struct {
    string      req;
    int         sel;
    logic [7:0] exp;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] wr_bus, periph_sel, periph_out, periph_oe, pin_in;
  logic       wr_data_en, wr_dir_en, rd_port_en, pullup_n, lvp_en, chg_clr;
  logic [7:0] rd_data, rd_dir, pin_out, pin_oe, pullup_en;
  logic       prog_in, chg_flag;

  item_t q[$];
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 0;

  always #2 clk = ~clk;

  bidir_port_ctl dut (
    .clk(clk), .rst_n(rst_n), .wr_bus(wr_bus), .wr_data_en(wr_data_en),
    .wr_dir_en(wr_dir_en), .rd_port_en(rd_port_en), .rd_data(rd_data),
    .rd_dir(rd_dir), .periph_sel(periph_sel), .periph_out(periph_out),
    .periph_oe(periph_oe), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .pullup_n(pullup_n), .pullup_en(pullup_en), .lvp_en(lvp_en),
    .prog_in(prog_in), .chg_clr(chg_clr), .chg_flag(chg_flag)
  );

  function automatic logic [7:0] observe(input int s);
    case (s)
      S_DIR:   return rd_dir;
      S_RD:    return rd_data;
      S_OUT:   return pin_out;
      S_OE:    return pin_oe;
      S_PU:    return pullup_en;
      S_FLAG:  return {7'd0, chg_flag};
      default: return {7'd0, prog_in};
    endcase
  endfunction

  // Driver side: expectation for the state seen just after the next rising edge
  task automatic expect_v(input string req, input int s, input logic [7:0] e);
    item_t it;
    it.req = req; it.sel = s; it.exp = e;
    q.push_back(it);
  endtask

  task automatic step();
    @(negedge clk);
    wr_data_en = 0; wr_dir_en = 0; rd_port_en = 0; chg_clr = 0;
  endtask

  // Monitor: compares once outputs have settled after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] a;
        it = q.pop_front();
        a  = observe(it.sel);
        n_chk++;
        if (a !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", it.req, a, it.exp);
        end
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_bus = 0; wr_data_en = 0; wr_dir_en = 0; rd_port_en = 0;
    periph_sel = 0; periph_out = 0; periph_oe = 0; pin_in = 0;
    pullup_n = 1; lvp_en = 0; chg_clr = 0;
    repeat (3) @(negedge clk);
    expect_v("R1 dir in reset", S_DIR, 8'hFF);
    expect_v("R1 oe in reset", S_OE, 8'h00);
    step(); rst_n = 1;
    step(); step(); step();
    expect_v("R1 dir", S_DIR, 8'hFF);
    expect_v("R1 out", S_OUT, 8'h00);
    expect_v("R1 oe", S_OE, 8'h00);
    expect_v("R1 flag", S_FLAG, 8'h00);

    step(); wr_data_en = 1; wr_bus = 8'hA5;
    expect_v("R2 data", S_OUT, 8'hA5);
    expect_v("R2 oe still off", S_OE, 8'h00);

    step(); wr_dir_en = 1; wr_bus = 8'h0F; pin_in = 8'h0C; pullup_n = 0;
    expect_v("R3 dir readback", S_DIR, 8'h0F);
    expect_v("R3 oe", S_OE, 8'hF0);
    expect_v("R5 sample", S_RD, 8'h0C);
    expect_v("R10 pullups", S_PU, 8'h0F);
    step();
    expect_v("R6 low bits quiet", S_FLAG, 8'h00);
    step();
    expect_v("R6 low bits quiet 2", S_FLAG, 8'h00);

    step(); periph_sel = 8'hFF; periph_out = 8'hFF; periph_oe = 8'hFF;
    expect_v("R4 periph out", S_OUT, 8'hAF);
    expect_v("R4 periph oe", S_OE, 8'hFE);
    step(); periph_out = 8'h00; periph_oe = 8'h00;
    expect_v("R4 periph out low", S_OUT, 8'hA1);
    expect_v("R4 periph oe off", S_OE, 8'hF0);
    step(); periph_sel = 8'h00;
    expect_v("R4 released", S_OUT, 8'hA5);

    step(); pin_in = 8'h1C;
    expect_v("R5 sample 1C", S_RD, 8'h1C);
    expect_v("R6 not yet", S_FLAG, 8'h00);
    step();
    expect_v("R6 flag set", S_FLAG, 8'h01);
    step(); chg_clr = 1;
    expect_v("R8 clear vs mismatch", S_FLAG, 8'h01);
    step(); rd_port_en = 1;
    expect_v("R8 sticky on read", S_FLAG, 8'h01);
    step(); chg_clr = 1;
    expect_v("R7 clear after read", S_FLAG, 8'h00);
    step();
    expect_v("R7 no new flag", S_FLAG, 8'h00);

    step(); pin_in = 8'h9C; rd_port_en = 1;
    expect_v("R7 read with change", S_FLAG, 8'h00);
    step();
    expect_v("R7 old sample was ref", S_FLAG, 8'h01);
    step(); rd_port_en = 1;
    step(); chg_clr = 1;
    expect_v("R8 cleared", S_FLAG, 8'h00);

    step(); lvp_en = 1; wr_dir_en = 1; wr_bus = 8'hFF;
    expect_v("R9 pullup bit4 off", S_PU, 8'hEF);
    expect_v("R9 prog high", S_PROG, 8'h01);
    step(); pin_in = 8'h8C;
    expect_v("R9 prog low", S_PROG, 8'h00);
    step();
    expect_v("R9 bit4 ignored", S_FLAG, 8'h00);
    step(); wr_dir_en = 1; wr_bus = 8'h00;
    expect_v("R9 bit4 no driver", S_OE, 8'hEF);
    expect_v("R10 outputs no pullup", S_PU, 8'h00);
    expect_v("R3 dir with pins", S_DIR, 8'h00);
    step(); lvp_en = 0; pullup_n = 1;
    expect_v("R9 prog off", S_PROG, 8'h00);
    expect_v("R9 bit4 driver back", S_OE, 8'hFF);
    step();
    step();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule